// File: doc/BRIEF.md
# Register-Mapped Serial Peripheral Master

This block is a serial peripheral master that sits on a simple 32-bit register bus. Software loads a chip-select channel and an end-of-frame tag into a transmit control register. A write of one byte to the transmit buffer then starts a full-duplex exchange on that channel. The serial clock comes from the bus clock through a power-of-two divider, and its idle level and sampling edge are programmable.

Every word carries its own channel and end-of-frame tag. The chip select of the channel stays asserted from word to word until a word tagged end-of-frame completes. When a word completes, the received byte is latched together with the channel and tag it was sent with, so software can check that both sides agree. Status flags report busy, receive-full and transmit-empty. Two latched event flags (receive overrun and frame end) are cleared by writing ones. An interrupt output combines the enabled flags.

Top module: `sermst_top`

## Requirements
- R1: After reset all chip selects are high, the serial clock is low, the interrupt output is low, the status register (0x44) reads 0 and the interrupt status register (0x68) reads 0x08 (only transmit-empty set).
- R2: The configuration register (0x40) reads back only bit 13 (clock phase), bit 14 (clock polarity) and bit 31 (enable). The rate register (0x48) reads back bits [3:0]. The transmit control register (0x4C) reads back bits [1:0] (channel) and bit 2 (end-of-frame). The enable register (0x6C) reads back bits [5:2]. All other bits read 0.
- R3: A write to the transmit buffer (0x50) while enabled and idle starts an exchange, and status bit 0 reads 1 while it runs. The exchange lasts exactly (17 + eof) x 2^(N-1) bus clocks, where N is the rate value and 0 is treated as 1. A write while disabled or while busy is ignored.
- R4: Data moves most significant bit first. The byte shifted out equals the written byte, and the byte shifted in reads from the receive buffer (0x58) bits [7:0].
- R5: The serial clock idles at the polarity bit. With phase 0, data is sampled on the leading clock edge of each bit; with phase 1, on the trailing edge.
- R6: From the start edge, only the selected channel's chip select is low. It stays low after a word with eof clear, goes high on the cycle the busy period of an eof word ends, and moves to the new channel when the next word selects another one.
- R7: The receive control register (0x54) reports in bits [1:0] the channel and in bit 2 the eof tag of the word that completed last.
- R8: Interrupt status bit 2 sets when a word completes and clears when the receive buffer is read. Bit 3 reads 1 exactly while no exchange runs.
- R9: Interrupt status bit 4 latches when a word completes while bit 2 is still set (overrun), and bit 5 latches when an eof word completes. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: The interrupt output is the OR of interrupt status bits [5:2], each masked by the same bit of the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects, one per channel |
| irq | output | 1 | Interrupt request |

## Verification
A behavioural model in the bench predicts the chip selects, the interrupt and the idle clock level on every cycle, and a serial slave model checks every bit in both directions under all four clock modes. With transmit-empty enabled as an interrupt source, the interrupt output shows the exact length of each busy period. An off-by-one in the phase count or in the rate decode, including rate 0, would show up as a mismatched cycle. The bench also goes after a chip select that drops between words of a frame or fails to move to a new channel, a second write during a transfer that corrupts the byte on the line, an overrun flag that misses a completion while the buffer is unread, and a write-one-to-clear that also clears on zeros.

// File: rtl/sermst_pkg.sv
package sermst_pkg;
   // Register byte offsets; software decodes these.
   localparam logic [7:0] OFS_CFG  = 8'h40;
   localparam logic [7:0] OFS_STAT = 8'h44;
   localparam logic [7:0] OFS_RATE = 8'h48;
   localparam logic [7:0] OFS_TXC  = 8'h4C;
   localparam logic [7:0] OFS_TXB  = 8'h50;
   localparam logic [7:0] OFS_RXC  = 8'h54;
   localparam logic [7:0] OFS_RXB  = 8'h58;
   localparam logic [7:0] OFS_IST  = 8'h68;
   localparam logic [7:0] OFS_IEN  = 8'h6C;
   // Field positions
   localparam int CFG_CPHA = 13;
   localparam int CFG_CPOL = 14;
   localparam int CFG_EN   = 31;
   localparam int TXC_EOF  = 2;
   localparam int IST_LO   = 2;   // flags occupy [5:2]
   localparam int IST_OVR  = 4;
   localparam int IST_FEOF = 5;
endpackage

// File: rtl/sermst_tick.sv
module sermst_tick #(
   parameter int RATE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);
   localparam int CNT_W = (1 << RATE_W) - 1;

   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  half_m1;
   logic [RATE_W-1:0] expo;

   always_comb begin
      expo    = (rate == '0) ? '0 : rate - RATE_W'(1);
      half_m1 = (CNT_W'(1) << expo) - CNT_W'(1);
   end

   assign tick = run && (cnt_q == half_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (!run || tick) cnt_q <= '0;
      else                  cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/sermst_engine.sv
module sermst_engine #(
   parameter int DATA_W = 8,
   parameter int CH_W   = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   tick,
   input  logic                   cpol,
   input  logic                   cpha,
   input  logic                   miso,
   input  logic                   tx_eof,
   input  logic [DATA_W-1:0]      tx_data,
   input  logic [CH_W-1:0]        tx_chan,
   output logic                   busy,
   output logic                   done,
   output logic                   sclk,
   output logic                   mosi,
   output logic [(1<<CH_W)-1:0]   cs_n,
   output logic [DATA_W-1:0]      rx_data,
   output logic [CH_W-1:0]        rx_chan,
   output logic                   rx_eof
);
   localparam int EDGES = 2 * DATA_W;
   localparam int PH_W  = $clog2(EDGES + 3);
   localparam int NCS   = 1 << CH_W;

   logic [PH_W-1:0]   ph_q, ev;
   logic [DATA_W-1:0] tx_sr, rx_sr;
   logic [CH_W-1:0]   chan_q;
   logic              eof_q, tog_q, hold_q;
   logic              in_edges, sample_ev, shift_ev, last_ev;

   always_comb begin
      ev        = ph_q + PH_W'(1);
      in_edges  = ev <= PH_W'(EDGES);
      // phase 0 samples on odd toggles, phase 1 on even toggles
      sample_ev = in_edges && (ev[0] ^ cpha);
      shift_ev  = in_edges && !(ev[0] ^ cpha) && (ev != PH_W'(1)) && (ev != PH_W'(EDGES));
      last_ev   = ev == (PH_W'(EDGES + 1) + PH_W'(eof_q));
   end

   assign done = busy && tick && last_ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; ph_q <= '0; tog_q <= 1'b0; hold_q <= 1'b0;
         tx_sr <= '0; rx_sr <= '0; chan_q <= '0; eof_q <= 1'b0;
      end else if (start && !busy) begin
         busy   <= 1'b1;
         ph_q   <= '0;
         tog_q  <= 1'b0;
         hold_q <= 1'b1;
         tx_sr  <= tx_data;
         chan_q <= tx_chan;
         eof_q  <= tx_eof;
      end else if (busy && tick) begin
         ph_q <= ev;
         if (in_edges)  tog_q <= ~tog_q;
         if (sample_ev) rx_sr <= {rx_sr[DATA_W-2:0], miso};
         if (shift_ev)  tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
         if (last_ev) begin
            busy   <= 1'b0;
            hold_q <= !eof_q;
         end
      end
   end

   assign sclk    = cpol ^ tog_q;
   assign mosi    = tx_sr[DATA_W-1];
   assign rx_data = rx_sr;
   assign rx_chan = chan_q;
   assign rx_eof  = eof_q;

   for (genvar g = 0; g < NCS; g++) begin : g_cs
      assign cs_n[g] = !(hold_q && (chan_q == CH_W'(g)));
   end
endmodule

// File: rtl/sermst_top.sv
module sermst_top
   import sermst_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int CH_W    = 2,
   parameter int RATE_W  = 4,
   parameter int ADDR_W  = 8,
   parameter int BUS_W   = 32,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   output logic                 sclk,
   output logic                 mosi,
   input  logic                 miso,
   output logic [(1<<CH_W)-1:0] cs_n,
   output logic                 irq
);
   if (DATA_W < 2 || DATA_W > 16) begin : g_bad_data
      $error("DATA_W out of range");
   end
   if (CH_W < 1 || CH_W > 2) begin : g_bad_ch
      $error("CH_W must fit below the eof bit");
   end
   if (RATE_W < 1 || RATE_W > 5) begin : g_bad_rate
      $error("RATE_W out of range");
   end
   if (ADDR_W < 8 || BUS_W < 32) begin : g_bad_bus
      $error("bus too narrow for register map");
   end

   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_RATE = ADDR_W'(OFS_RATE);
   localparam logic [ADDR_W-1:0] A_TXC  = ADDR_W'(OFS_TXC);
   localparam logic [ADDR_W-1:0] A_TXB  = ADDR_W'(OFS_TXB);
   localparam logic [ADDR_W-1:0] A_RXC  = ADDR_W'(OFS_RXC);
   localparam logic [ADDR_W-1:0] A_RXB  = ADDR_W'(OFS_RXB);
   localparam logic [ADDR_W-1:0] A_IST  = ADDR_W'(OFS_IST);
   localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFS_IEN);

   logic              en_q, cpol_q, cpha_q;
   logic [RATE_W-1:0] rate_q;
   logic [CH_W-1:0]   txc_chan_q, rxc_chan_q;
   logic              txc_eof_q, rxc_eof_q;
   logic [DATA_W-1:0] rxb_q;
   logic              rxf_q, ovr_q, feof_q;
   logic [3:0]        ien_q;
   logic              wr_any, rd_rxb, start, tick, busy, done;
   logic [DATA_W-1:0] eng_rx;
   logic [CH_W-1:0]   eng_chan;
   logic              eng_eof, irq_c;
   logic [3:0]        ist_v;
   logic              unused_wdata;

   assign unused_wdata = ^bus_wdata;
   assign wr_any = bus_sel && bus_wr;
   assign rd_rxb = bus_sel && !bus_wr && (bus_addr == A_RXB);
   assign start  = wr_any && (bus_addr == A_TXB) && en_q && !busy;

   sermst_tick #(.RATE_W(RATE_W)) tick_i (
      .clk(clk), .rst_n(rst_n), .run(busy), .rate(rate_q), .tick(tick)
   );

   sermst_engine #(.DATA_W(DATA_W), .CH_W(CH_W)) eng_i (
      .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
      .cpol(cpol_q), .cpha(cpha_q), .miso(miso), .tx_eof(txc_eof_q),
      .tx_data(bus_wdata[DATA_W-1:0]), .tx_chan(txc_chan_q),
      .busy(busy), .done(done), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
      .rx_data(eng_rx), .rx_chan(eng_chan), .rx_eof(eng_eof)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0; rate_q <= '0;
         txc_chan_q <= '0; txc_eof_q <= 1'b0; ien_q <= '0;
      end else if (wr_any) begin
         if (bus_addr == A_CFG) begin
            en_q   <= bus_wdata[CFG_EN];
            cpol_q <= bus_wdata[CFG_CPOL];
            cpha_q <= bus_wdata[CFG_CPHA];
         end
         if (bus_addr == A_RATE) rate_q <= bus_wdata[RATE_W-1:0];
         if (bus_addr == A_TXC) begin
            txc_chan_q <= bus_wdata[CH_W-1:0];
            txc_eof_q  <= bus_wdata[TXC_EOF];
         end
         if (bus_addr == A_IEN) ien_q <= bus_wdata[IST_LO+3:IST_LO];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxb_q <= '0; rxc_chan_q <= '0; rxc_eof_q <= 1'b0;
         rxf_q <= 1'b0; ovr_q <= 1'b0; feof_q <= 1'b0;
      end else begin
         if (done) begin
            rxb_q      <= eng_rx;
            rxc_chan_q <= eng_chan;
            rxc_eof_q  <= eng_eof;
         end
         if (done)        rxf_q <= 1'b1;
         else if (rd_rxb) rxf_q <= 1'b0;
         if (done && rxf_q && !rd_rxb)                              ovr_q <= 1'b1;
         else if (wr_any && bus_addr == A_IST && bus_wdata[IST_OVR]) ovr_q <= 1'b0;
         if (done && eng_eof)                                        feof_q <= 1'b1;
         else if (wr_any && bus_addr == A_IST && bus_wdata[IST_FEOF]) feof_q <= 1'b0;
      end
   end

   assign ist_v = {feof_q, ovr_q, ~busy, rxf_q};
   assign irq_c = |(ist_v & ien_q);

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_c;
      end
   end else begin : g_irq_comb
      assign irq = irq_c;
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CFG: begin
            bus_rdata[CFG_EN]   = en_q;
            bus_rdata[CFG_CPOL] = cpol_q;
            bus_rdata[CFG_CPHA] = cpha_q;
         end
         A_STAT: bus_rdata[0] = busy;
         A_RATE: bus_rdata[RATE_W-1:0] = rate_q;
         A_TXC: begin
            bus_rdata[CH_W-1:0] = txc_chan_q;
            bus_rdata[TXC_EOF]  = txc_eof_q;
         end
         A_RXC: begin
            bus_rdata[CH_W-1:0] = rxc_chan_q;
            bus_rdata[TXC_EOF]  = rxc_eof_q;
         end
         A_RXB: bus_rdata[DATA_W-1:0] = rxb_q;
         A_IST: bus_rdata[IST_LO+3:IST_LO] = ist_v;
         A_IEN: bus_rdata[IST_LO+3:IST_LO] = ien_q;
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/sermst_chk.sv
module sermst_chk
   import sermst_pkg::*;
#(
   parameter int CH_W   = 2,
   parameter int ADDR_W = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_sel,
   input logic                 bus_wr,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic                 busy,
   input logic [(1<<CH_W)-1:0] cs_n,
   input logic                 sclk,
   input logic                 cpol,
   input logic                 rxfull,
   input logic [3:0]           ien,
   input logic                 irq
);
   // R6: at most one chip select active
   p_cs_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~cs_n) <= 1);
   // R6: a running word always has a selected device
   p_busy_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cs_n != '1));
   // R5: clock rests at polarity level between words
   p_idle_sclk_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sclk == cpol));
   // R3: a transfer only begins after a transmit-buffer write
   p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_TXB)));
   // R8: completion leaves the receive buffer full
   p_done_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> rxfull);
   // R10: no interrupt while every source is masked
   p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == '0 && $past(ien) == '0) |-> !irq);
endmodule

bind sermst_top sermst_chk #(.CH_W(CH_W), .ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .busy(busy), .cs_n(cs_n), .sclk(sclk),
   .cpol(cpol_q), .rxfull(rxf_q), .ien(ien_q), .irq(irq)
);

// File: tb/sermst_top_tb.sv
module sermst_top_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        sclk, mosi, miso = 1'b0, irq;
   logic [3:0]  cs_n;

   int n_chk = 0, n_err = 0;
   bit run_cmp = 0;

   sermst_top dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   int         m_rem;
   logic [3:0] m_cs, m_ien, m_rate;
   bit         m_rxf, m_ovr, m_feof, m_en, m_cpol, m_teof, m_ceof;
   logic [1:0] m_tch;
   bit         s_cpha;

   always @(posedge clk) begin
      bit wr_now, rdrx, busy_old, done_now, rxf_old;
      int h;
      if (!rst_n) begin
         m_rem = 0; m_cs = 4'hF; m_rxf = 0; m_ovr = 0; m_feof = 0; m_ien = 0;
         m_en = 0; m_cpol = 0; s_cpha = 0; m_rate = 0; m_tch = 0; m_teof = 0; m_ceof = 0;
      end else begin
         wr_now   = bus_sel && bus_wr;
         rdrx     = bus_sel && !bus_wr && bus_addr == 8'h58;
         busy_old = (m_rem != 0);
         done_now = (m_rem == 1);
         rxf_old  = m_rxf;
         if (wr_now && bus_addr == 8'h68) begin
            if (bus_wdata[4]) m_ovr = 0;
            if (bus_wdata[5]) m_feof = 0;
         end
         if (rdrx) m_rxf = 0;
         if (busy_old) begin
            m_rem--;
            if (done_now) begin
               if (rxf_old && !rdrx) m_ovr = 1;
               m_rxf = 1;
               if (m_ceof) begin m_feof = 1; m_cs = 4'hF; end
            end
         end
         if (wr_now && bus_addr == 8'h50 && m_en && !busy_old) begin
            h = 1 << ((m_rate == 0) ? 0 : m_rate - 1);
            m_rem  = (17 + int'(m_teof)) * h;
            m_cs   = ~(4'b1 << m_tch);
            m_ceof = m_teof;
         end
         if (wr_now && bus_addr == 8'h40) begin
            m_en = bus_wdata[31]; m_cpol = bus_wdata[14]; s_cpha = bus_wdata[13];
         end
         if (wr_now && bus_addr == 8'h48) m_rate = bus_wdata[3:0];
         if (wr_now && bus_addr == 8'h4C) begin m_tch = bus_wdata[1:0]; m_teof = bus_wdata[2]; end
         if (wr_now && bus_addr == 8'h6C) m_ien = bus_wdata[5:2];
      end
   end

   // per-cycle comparison
   always @(negedge clk) begin
      logic exp_irq;
      if (run_cmp && rst_n) begin
         exp_irq = |({m_feof, m_ovr, (m_rem == 0), m_rxf} & m_ien);
         chk(cs_n == m_cs, "R6 chip select", {28'b0, cs_n}, {28'b0, m_cs});
         chk(irq == exp_irq, "R10/R3 irq", {31'b0, irq}, {31'b0, exp_irq});
         if (m_rem == 0)
            chk(sclk == m_cpol, "R5 idle sclk", {31'b0, sclk}, {31'b0, m_cpol});
      end
   end

   // ---------------- serial slave model ----------------
   logic [7:0] s_reply, s_got;
   int         tg;

   always @(sclk) begin
      if (rst_n && cs_n != 4'hF) begin
         tg++;
         if (((tg % 2) == 1) != s_cpha) s_got = {s_got[6:0], mosi};
         else if (tg > 1 && tg < 16) miso = s_reply[7 - tg/2];
      end
   end

   // ---------------- bus tasks ----------------
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 0;
   endtask

   task automatic cfg(input bit en, input bit cpol, input bit cpha);
      logic [31:0] v;
      v = '0; v[31] = en; v[14] = cpol; v[13] = cpha;
      wr(8'h40, v);
   endtask

   task automatic start_word(input logic [7:0] d, input logic [7:0] rep, input logic [1:0] ch, input bit eof);
      wr(8'h4C, {29'b0, eof, ch});
      s_reply = rep; miso = rep[7]; tg = 0; s_got = '0;
      wr(8'h50, {24'b0, d});
   endtask

   task automatic wait_idle;
      do @(negedge clk); while (m_rem != 0);
   endtask

   task automatic full_word(input logic [7:0] d, input logic [7:0] rep, input logic [1:0] ch, input bit eof);
      logic [31:0] v;
      start_word(d, rep, ch, eof);
      wait_idle();
      chk(s_got == d, "R4 mosi byte", {24'b0, s_got}, {24'b0, d});
      rd(8'h68, v);
      chk(v[2] == 1'b1, "R8 rxfull set", v, 32'h4);
      rd(8'h58, v);
      chk(v == {24'b0, rep}, "R4 rx byte", v, {24'b0, rep});
      rd(8'h54, v);
      chk(v == {29'b0, eof, ch}, "R7 rx tags", v, {29'b0, eof, ch});
      rd(8'h68, v);
      chk(v[2] == 1'b0, "R8 rxfull cleared by read", v, 32'h0);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      run_cmp = 1;
      // R1 reset state
      chk(cs_n == 4'hF && sclk == 1'b0 && irq == 1'b0, "R1 reset pins", {27'b0, irq, sclk, cs_n}, 32'hF);
      rd(8'h44, v); chk(v == 32'h0, "R1 status", v, 32'h0);
      rd(8'h68, v); chk(v == 32'h8, "R1 int status", v, 32'h8);

      // R2 readback masks
      wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, v); chk(v == 32'h8000_6000, "R2 config", v, 32'h8000_6000);
      wr(8'h48, 32'hFFFF_FFF3); rd(8'h48, v); chk(v == 32'h3, "R2 rate", v, 32'h3);
      wr(8'h4C, 32'hFFFF_FFFF); rd(8'h4C, v); chk(v == 32'h7, "R2 txctl", v, 32'h7);
      wr(8'h6C, 32'hFFFF_FFFF); rd(8'h6C, v); chk(v == 32'h3C, "R2 enable", v, 32'h3C);
      wr(8'h6C, 32'h0);

      // R4 R5 R6 R7 mode 0, rate 1
      cfg(1, 0, 0); wr(8'h48, 32'h1);
      full_word(8'hA5, 8'h3C, 2'd1, 1);
      rd(8'h68, v); chk(v[5] == 1'b1, "R9 frame-end latched", v, 32'h28);
      wr(8'h68, 32'h0); rd(8'h68, v); chk(v[5] == 1'b1, "R9 zero write keeps flag", v, 32'h28);
      wr(8'h68, 32'h20); rd(8'h68, v); chk(v[5] == 1'b0, "R9 W1C clears frame-end", v, 32'h8);

      // R3 status busy mid-transfer
      start_word(8'h0F, 8'hF0, 2'd0, 1);
      repeat (3) @(negedge clk);
      rd(8'h44, v); chk(v == 32'h1, "R3 busy reads 1", v, 32'h1);
      wait_idle(); rd(8'h58, v);
      chk(v == 32'hF0, "R4 rx byte", v, 32'hF0);

      // R5 R6 mode 3, rate 2, frame of two words with held select
      cfg(1, 1, 1); wr(8'h48, 32'h2); wr(8'h6C, 32'h08);
      full_word(8'h5A, 8'hC3, 2'd2, 0);
      chk(cs_n == 4'b1011, "R6 select held between words", {28'b0, cs_n}, 32'hB);
      full_word(8'h81, 8'h7E, 2'd2, 1);
      chk(cs_n == 4'hF, "R6 released after eof", {28'b0, cs_n}, 32'hF);

      // R5 mode 1 at rate 0 (treated as 1) and channel switch
      cfg(1, 0, 1); wr(8'h48, 32'h0);
      full_word(8'h96, 8'h69, 2'd0, 0);
      full_word(8'h3E, 8'hE3, 2'd3, 1);

      // R5 mode 2 at rate 3
      cfg(1, 1, 0); wr(8'h48, 32'h3);
      full_word(8'hC1, 8'h1C, 2'd1, 1);

      // R3 write while busy ignored
      cfg(1, 0, 0); wr(8'h48, 32'h1);
      start_word(8'h96, 8'h55, 2'd0, 1);
      repeat (4) @(negedge clk);
      wr(8'h50, 32'h11);
      wait_idle();
      chk(s_got == 8'h96, "R3 busy write ignored", {24'b0, s_got}, 32'h96);
      rd(8'h58, v); chk(v == 32'h55, "R3 rx after ignored write", v, 32'h55);

      // R3 write while disabled ignored
      cfg(0, 0, 0);
      wr(8'h50, 32'hAA);
      repeat (10) @(negedge clk);
      rd(8'h44, v); chk(v == 32'h0, "R3 disabled write ignored", v, 32'h0);
      chk(cs_n == 4'hF, "R3 no select when disabled", {28'b0, cs_n}, 32'hF);

      // R9 R10 overrun and interrupt sources
      cfg(1, 0, 0); wr(8'h6C, 32'h14);
      start_word(8'h12, 8'h34, 2'd1, 1); wait_idle();
      chk(irq == 1'b1, "R10 rxfull irq", {31'b0, irq}, 32'h1);
      start_word(8'h56, 8'h78, 2'd1, 1); wait_idle();
      rd(8'h68, v); chk(v[4] == 1'b1, "R9 overrun latched", v, 32'h3C);
      rd(8'h58, v); chk(v == 32'h78, "R4 newest byte kept", v, 32'h78);
      chk(irq == 1'b1, "R10 overrun irq", {31'b0, irq}, 32'h1);
      wr(8'h68, 32'h10); rd(8'h68, v); chk(v[4] == 1'b0, "R9 overrun W1C", v, 32'h28);
      chk(irq == 1'b0, "R10 irq clears", {31'b0, irq}, 32'h0);

      repeat (5) @(negedge clk);
      run_cmp = 0;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule